// File: doc/BRIEF.md
# Voice Key-On/Key-Off Controller

This block owns the per-voice start and release control of a 24-voice sample-playback engine. Software issues restart and release requests as bitmasks through a single 16-bit write port. The 24 voice bits are split over two words: a low word for voices 0 to 15 and a high word whose bits 7:0 select voices 16 to 23. The same port also loads three 20-bit address registers per voice: the start address, the loop-start address and the running next address. Each address is written as a 4-bit upper half and a 16-bit lower half.

A restart that the block accepts does several things at once. It puts the voice envelope into its attack state and reloads the next-address pointer from the start address, rounded up to an 8-word boundary. It stamps the voice with the current sample-tick count, clears its loop mode and its end flag, and raises a one-cycle restart pulse. The decoder uses that pulse to flush its history and loop flags. A voice cannot be restarted again until at least 4 sample ticks have passed since its last accepted restart. A separate stop mask lets the engine silence voices immediately. Sample decoding, pitch stepping and envelope rate arithmetic live elsewhere.

Top module: `voice_key_ctrl`

## Requirements
- R1: After reset, every voice reads start, loop, next, loop mode, phase, envelope value, release flag and play tick as 0. The end flags and restart pulses are all 0. The first restart request for any voice after reset is accepted.
- R2: Write select 4 (start), 6 (loop) or 8 (next) is an upper-half write. It sets address bits 19:16 from data bits 3:0 and keeps bits 15:3, with bits 2:0 forced to 0. Write select 5, 7 or 9 is a lower-half write. It sets bits 15:0 to data AND 0xFFF8 and keeps bits 19:16. Write selects 10 to 15 change nothing.
- R3: A write to either half of the loop-start address (select 6 or 7) sets that voice's loop mode to 3.
- R4: Select 0 is a restart request for voices 0 to 15, with data bit i selecting voice i. Select 1 does the same for voices 16 to 23, with data bits 7:0. A zero mask changes nothing.
- R5: An accepted restart sets phase 1, envelope value 1 and release 0, clears the loop mode to 0, and stores the current tick count as play tick. It also pulses that voice's restart_pulse bit for exactly the following cycle.
- R6: A restart request is accepted only if the voice has seen at least 4 tick pulses since its last accepted restart. Otherwise the request changes nothing and raises no pulse. A tick in the same cycle as an accepted restart is not counted towards the next gap.
- R7: An end_set bit sets that voice's end flag. An accepted restart clears the end flag, and it wins over an end_set bit for the same voice in the same cycle.
- R8: Select 2 (voices 0 to 15) and select 3 (voices 16 to 23, bits 7:0) are release requests. Each selected voice gets its release flag set, and nothing else changes. A zero mask changes nothing.
- R9: A stop_mask bit forces that voice's phase and envelope value to 0 on the next clock edge. An accepted restart of the same voice in the same cycle wins over the stop. A dropped restart does not block the stop.
- R10: On an accepted restart, next becomes the start address rounded up to a multiple of 8, modulo 2^20. So next is always 8-word aligned after a restart.
- R11: The play tick stored by a restart equals the number of tick pulses seen since reset, modulo 2^16, not counting a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample tick strobe |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write select (see R2, R4, R8) |
| wr_voice | input | 5 | Voice index for address writes |
| wr_data | input | 16 | Write data or voice mask word |
| stop_mask | input | 24 | Per-voice immediate stop request |
| end_set | input | 24 | Per-voice end-reached event from the decoder |
| rd_voice | input | 5 | Voice index for the read port |
| end_flags | output | 24 | Per-voice end flags |
| restart_pulse | output | 24 | One-cycle pulse per accepted restart |
| rd_start | output | 20 | Start address of rd_voice |
| rd_loop | output | 20 | Loop-start address of rd_voice |
| rd_next | output | 20 | Next address of rd_voice |
| rd_loop_mode | output | 2 | Loop mode of rd_voice |
| rd_phase | output | 3 | Envelope phase of rd_voice |
| rd_env | output | 16 | Envelope value of rd_voice |
| rd_release | output | 1 | Release flag of rd_voice |
| rd_play_tick | output | 16 | Tick count stamped at the last restart of rd_voice |

## Verification
Three pairs of events can land in one cycle. A restart can meet a stop request for the same voice, a restart can meet an end-reached event, and a restart can meet a tick. The bench drives each pair on the same clock edge and judges the outcome from the voice state read back on the next cycle: a restart that is accepted must leave the attack state and a cleared end flag. The same stop is also paired with a restart that the 4-tick gate drops, where the stop must take effect.

// File: rtl/vkc_pkg.sv
package vkc_pkg;
  localparam int ADDR_W = 20;

  typedef enum logic [3:0] {
    SEL_KON_LO   = 4'd0,
    SEL_KON_HI   = 4'd1,
    SEL_KOFF_LO  = 4'd2,
    SEL_KOFF_HI  = 4'd3,
    SEL_START_HI = 4'd4,
    SEL_START_LO = 4'd5,
    SEL_LOOP_HI  = 4'd6,
    SEL_LOOP_LO  = 4'd7,
    SEL_NEXT_HI  = 4'd8,
    SEL_NEXT_LO  = 4'd9
  } wsel_e;

  // Upper-half merge: data[3:0] land in bits 19:16, lower bits stay aligned.
  function automatic logic [ADDR_W-1:0] f_set_hi(logic [ADDR_W-1:0] cur, logic [15:0] d);
    return {d[3:0], cur[15:3], 3'b000};
  endfunction

  // Lower-half merge: data masked to an 8-word boundary, bits 19:16 stay.
  function automatic logic [ADDR_W-1:0] f_set_lo(logic [ADDR_W-1:0] cur, logic [15:0] d);
    return {cur[ADDR_W-1:16], d[15:3], 3'b000};
  endfunction

  // Round up to a multiple of 8, wrapping inside the address width.
  function automatic logic [ADDR_W-1:0] f_align_up(logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] s;
    s = {1'b0, a} + (ADDR_W+1)'(7);
    return {s[ADDR_W-1:3], 3'b000};
  endfunction
endpackage

// File: rtl/vk_gate.sv
module vk_gate #(
  parameter int NV  = 24,
  parameter int GAP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NV-1:0] req,
  output logic [NV-1:0] acc
);
  localparam int GAP_W = $clog2(GAP + 1);

  for (genvar v = 0; v < NV; v++) begin : g_voice
    logic [GAP_W-1:0] age;

    assign acc[v] = req[v] && (age >= GAP_W'(GAP));

    always_ff @(posedge clk) begin
      if (!rst_n)                           age <= GAP_W'(GAP);
      else if (acc[v])                      age <= '0;
      else if (tick && age < GAP_W'(GAP))   age <= age + 1'b1;
    end

    // R6: a voice just restarted cannot be restarted on the very next cycle
    p_no_rekey_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc[v] |=> !acc[v]);
  end
endmodule

// File: rtl/vk_env.sv
module vk_env #(
  parameter int NV    = 24,
  parameter int ENV_W = 16,
  parameter int PH_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NV-1:0]             acc,
  input  logic [NV-1:0]             koff,
  input  logic [NV-1:0]             stop,
  output logic [NV-1:0][PH_W-1:0]   phase,
  output logic [NV-1:0][ENV_W-1:0]  env,
  output logic [NV-1:0]             rel
);
  for (genvar v = 0; v < NV; v++) begin : g_voice
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        phase[v] <= '0;
        env[v]   <= '0;
        rel[v]   <= 1'b0;
      end else if (acc[v]) begin
        phase[v] <= PH_W'(1);
        env[v]   <= ENV_W'(1);
        rel[v]   <= 1'b0;
      end else begin
        if (stop[v]) begin
          phase[v] <= '0;
          env[v]   <= '0;
        end
        if (koff[v]) rel[v] <= 1'b1;
      end
    end

    p_attack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc[v] |=> (phase[v] == PH_W'(1)) && (env[v] == ENV_W'(1)) && !rel[v]);
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      koff[v] && !acc[v] |=> rel[v]);
    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop[v] && !acc[v] |=> (env[v] == '0) && (phase[v] == '0));
  end
endmodule

// File: rtl/vk_addr.sv
module vk_addr
  import vkc_pkg::*;
#(
  parameter int NV = 24,
  parameter int TW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [3:0]                   wr_sel,
  input  logic [$clog2(NV)-1:0]        wr_voice,
  input  logic [15:0]                  wr_data,
  input  logic [NV-1:0]                acc,
  input  logic [TW-1:0]                tick_cnt,
  output logic [NV-1:0][ADDR_W-1:0]    start_a,
  output logic [NV-1:0][ADDR_W-1:0]    loop_a,
  output logic [NV-1:0][ADDR_W-1:0]    next_a,
  output logic [NV-1:0][1:0]           lmode,
  output logic [NV-1:0][TW-1:0]        ptick
);
  localparam int VI_W = $clog2(NV);

  for (genvar v = 0; v < NV; v++) begin : g_voice
    logic hit;
    assign hit = wr_en && (wr_voice == VI_W'(v));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        start_a[v] <= '0;
        loop_a[v]  <= '0;
        next_a[v]  <= '0;
        lmode[v]   <= '0;
        ptick[v]   <= '0;
      end else begin
        if (hit) begin
          case (wsel_e'(wr_sel))
            SEL_START_HI: start_a[v] <= f_set_hi(start_a[v], wr_data);
            SEL_START_LO: start_a[v] <= f_set_lo(start_a[v], wr_data);
            SEL_LOOP_HI: begin
              loop_a[v] <= f_set_hi(loop_a[v], wr_data);
              lmode[v]  <= 2'd3;
            end
            SEL_LOOP_LO: begin
              loop_a[v] <= f_set_lo(loop_a[v], wr_data);
              lmode[v]  <= 2'd3;
            end
            SEL_NEXT_HI: next_a[v] <= f_set_hi(next_a[v], wr_data);
            SEL_NEXT_LO: next_a[v] <= f_set_lo(next_a[v], wr_data);
            default: ;
          endcase
        end
        if (acc[v]) begin
          next_a[v] <= f_align_up(start_a[v]);
          lmode[v]  <= 2'd0;
          ptick[v]  <= tick_cnt;
        end
      end
    end

    p_next_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc[v] |=> (next_a[v][2:0] == 3'b000));
    p_loop_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !acc[v] && ((wr_sel == 4'd6) || (wr_sel == 4'd7)) |=> (lmode[v] == 2'd3));
  end
endmodule

// File: rtl/voice_key_ctrl.sv
module voice_key_ctrl
  import vkc_pkg::*;
#(
  parameter int NV    = 24,
  parameter int GAP   = 4,
  parameter int TW    = 16,
  parameter int ENV_W = 16,
  parameter int PH_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   wr_en,
  input  logic [3:0]             wr_sel,
  input  logic [$clog2(NV)-1:0]  wr_voice,
  input  logic [15:0]            wr_data,
  input  logic [NV-1:0]          stop_mask,
  input  logic [NV-1:0]          end_set,
  input  logic [$clog2(NV)-1:0]  rd_voice,
  output logic [NV-1:0]          end_flags,
  output logic [NV-1:0]          restart_pulse,
  output logic [19:0]            rd_start,
  output logic [19:0]            rd_loop,
  output logic [19:0]            rd_next,
  output logic [1:0]             rd_loop_mode,
  output logic [PH_W-1:0]        rd_phase,
  output logic [ENV_W-1:0]       rd_env,
  output logic                   rd_release,
  output logic [TW-1:0]          rd_play_tick
);
  localparam int WORD_W = 16;

  logic [NV-1:0]                kon_mask, koff_mask, acc;
  logic [TW-1:0]                tick_cnt;
  logic [NV-1:0][ADDR_W-1:0]    start_a, loop_a, next_a;
  logic [NV-1:0][1:0]           lmode;
  logic [NV-1:0][TW-1:0]        ptick;
  logic [NV-1:0][PH_W-1:0]      phase;
  logic [NV-1:0][ENV_W-1:0]     env;
  logic [NV-1:0]                rel;

  // Voice v lives in word v/16 of a mask, at bit v%16.
  always_comb begin
    kon_mask  = '0;
    koff_mask = '0;
    for (int v = 0; v < NV; v++) begin
      if (wr_en && wr_sel == ((v / WORD_W == 0) ? 4'(SEL_KON_LO) : 4'(SEL_KON_HI)))
        kon_mask[v] = wr_data[v % WORD_W];
      if (wr_en && wr_sel == ((v / WORD_W == 0) ? 4'(SEL_KOFF_LO) : 4'(SEL_KOFF_HI)))
        koff_mask[v] = wr_data[v % WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_cnt <= '0;
    else if (tick) tick_cnt <= tick_cnt + 1'b1;
  end

  vk_gate #(.NV(NV), .GAP(GAP)) u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(kon_mask), .acc(acc)
  );

  vk_env #(.NV(NV), .ENV_W(ENV_W), .PH_W(PH_W)) u_env (
    .clk(clk), .rst_n(rst_n), .acc(acc), .koff(koff_mask), .stop(stop_mask),
    .phase(phase), .env(env), .rel(rel)
  );

  vk_addr #(.NV(NV), .TW(TW)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_voice(wr_voice),
    .wr_data(wr_data), .acc(acc), .tick_cnt(tick_cnt),
    .start_a(start_a), .loop_a(loop_a), .next_a(next_a), .lmode(lmode), .ptick(ptick)
  );

  for (genvar v = 0; v < NV; v++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        end_flags[v]     <= 1'b0;
        restart_pulse[v] <= 1'b0;
      end else begin
        restart_pulse[v] <= acc[v];
        if (acc[v])          end_flags[v] <= 1'b0;
        else if (end_set[v]) end_flags[v] <= 1'b1;
      end
    end

    p_end_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc[v] |=> !end_flags[v]);
  end

  logic rd_ok;
  assign rd_ok = int'(rd_voice) < NV;

  always_comb begin
    rd_start     = rd_ok ? start_a[rd_voice] : '0;
    rd_loop      = rd_ok ? loop_a[rd_voice]  : '0;
    rd_next      = rd_ok ? next_a[rd_voice]  : '0;
    rd_loop_mode = rd_ok ? lmode[rd_voice]   : '0;
    rd_phase     = rd_ok ? phase[rd_voice]   : '0;
    rd_env       = rd_ok ? env[rd_voice]     : '0;
    rd_release   = rd_ok ? rel[rd_voice]     : 1'b0;
    rd_play_tick = rd_ok ? ptick[rd_voice]   : '0;
  end
endmodule

// File: tb/voice_key_ctrl_tb.sv
`timescale 1ns/1ps
module voice_key_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [4:0] wr_voice = '0, rd_voice = '0;
  logic [15:0] wr_data = '0;
  logic [23:0] stop_mask = '0, end_set = '0;
  logic [23:0] end_flags, restart_pulse;
  logic [19:0] rd_start, rd_loop, rd_next;
  logic [1:0] rd_loop_mode;
  logic [2:0] rd_phase;
  logic [15:0] rd_env, rd_play_tick;
  logic rd_release;

  always #2.5 clk = ~clk;

  voice_key_ctrl u_dut (.*);

  typedef struct {
    string req; int v;
    logic [19:0] st, lp, nx; logic [1:0] lm; logic [2:0] ph;
    logic [15:0] env; logic rel; logic [15:0] pt; logic [23:0] ef, pu;
  } item_t;
  item_t q[$];
  int checks = 0, errors = 0;

  // reference model
  logic [19:0] m_st[24], m_lp[24], m_nx[24];
  logic [1:0]  m_lm[24];
  logic [2:0]  m_ph[24];
  logic [15:0] m_env[24], m_pt[24];
  logic        m_rel[24];
  int          m_age[24];
  logic [23:0] m_ef, m_pu;
  logic [15:0] m_tick;

  task automatic chk(string req, string f, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, f, a, e);
    end
  endtask

  // monitor: compares queued expectations while the state is stable
  initial forever begin
    @(negedge clk); #0.5;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      rd_voice = 5'(it.v); #0.1;
      chk(it.req, "start", 32'(rd_start), 32'(it.st));
      chk(it.req, "loop", 32'(rd_loop), 32'(it.lp));
      chk(it.req, "next", 32'(rd_next), 32'(it.nx));
      chk(it.req, "lmode", 32'(rd_loop_mode), 32'(it.lm));
      chk(it.req, "phase", 32'(rd_phase), 32'(it.ph));
      chk(it.req, "env", 32'(rd_env), 32'(it.env));
      chk(it.req, "rel", 32'(rd_release), 32'(it.rel));
      chk(it.req, "ptick", 32'(rd_play_tick), 32'(it.pt));
      chk(it.req, "endflags", 32'(end_flags), 32'(it.ef));
      chk(it.req, "pulse", 32'(restart_pulse), 32'(it.pu));
    end
  end

  task automatic expect_v(string req, int v);
    item_t it;
    it.req = req; it.v = v; it.st = m_st[v]; it.lp = m_lp[v]; it.nx = m_nx[v];
    it.lm = m_lm[v]; it.ph = m_ph[v]; it.env = m_env[v]; it.rel = m_rel[v];
    it.pt = m_pt[v]; it.ef = m_ef; it.pu = m_pu;
    q.push_back(it);
  endtask

  // drive one cycle (called at a negedge) and advance the model
  task automatic step(bit en, logic [3:0] sel, int voice, logic [15:0] d,
                      bit tk, logic [23:0] stp, logic [23:0] es);
    logic [23:0] km, fm, ac;
    wr_en = en; wr_sel = sel; wr_voice = 5'(voice); wr_data = d;
    tick = tk; stop_mask = stp; end_set = es;
    km = '0; fm = '0; ac = '0;
    if (en && sel == 4'd0) km[15:0]  = d;
    if (en && sel == 4'd1) km[23:16] = d[7:0];
    if (en && sel == 4'd2) fm[15:0]  = d;
    if (en && sel == 4'd3) fm[23:16] = d[7:0];
    for (int v = 0; v < 24; v++) begin
      ac[v] = km[v] && (m_age[v] >= 4);
      if (ac[v]) begin
        m_ph[v] = 3'd1; m_env[v] = 16'd1; m_rel[v] = 1'b0; m_lm[v] = 2'd0;
        m_nx[v] = 20'((((m_st[v] + 21'd7) >> 3) << 3));
        m_pt[v] = m_tick; m_age[v] = 0; m_ef[v] = 1'b0;
      end else begin
        if (stp[v]) begin m_ph[v] = '0; m_env[v] = '0; end
        if (fm[v]) m_rel[v] = 1'b1;
        if (es[v]) m_ef[v] = 1'b1;
        if (tk && m_age[v] < 4) m_age[v]++;
      end
    end
    if (en) case (sel)
      4'd4: m_st[voice] = 20'((d & 16'hF) << 16) | (m_st[voice] & 20'h0FFF8);
      4'd5: m_st[voice] = (m_st[voice] & 20'hF0000) | 20'(d & 16'hFFF8);
      4'd6: begin m_lp[voice] = 20'((d & 16'hF) << 16) | (m_lp[voice] & 20'h0FFF8); m_lm[voice] = 2'd3; end
      4'd7: begin m_lp[voice] = (m_lp[voice] & 20'hF0000) | 20'(d & 16'hFFF8); m_lm[voice] = 2'd3; end
      4'd8: m_nx[voice] = 20'((d & 16'hF) << 16) | (m_nx[voice] & 20'h0FFF8);
      4'd9: m_nx[voice] = (m_nx[voice] & 20'hF0000) | 20'(d & 16'hFFF8);
      default: ;
    endcase
    m_pu = ac;
    if (tk) m_tick++;
    @(negedge clk);
    wr_en = 0; tick = 0; stop_mask = '0; end_set = '0;
  endtask

  task automatic wr(logic [3:0] sel, int voice, logic [15:0] d);
    step(1'b1, sel, voice, d, 1'b0, '0, '0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 0, '0, 1'b1, '0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int v = 0; v < 24; v++) begin
      m_st[v] = '0; m_lp[v] = '0; m_nx[v] = '0; m_lm[v] = '0; m_ph[v] = '0;
      m_env[v] = '0; m_pt[v] = '0; m_rel[v] = 0; m_age[v] = 4;
    end
    m_ef = '0; m_pu = '0; m_tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_v("R1", 0); expect_v("R1", 23);
    // R2 address halves, R3 loop mode
    wr(4'd4, 3, 16'hFFF5); expect_v("R2", 3);
    wr(4'd5, 3, 16'h1237); expect_v("R2", 3);
    wr(4'd9, 4, 16'hABCF); wr(4'd8, 4, 16'h0002); expect_v("R2", 4);
    wr(4'd7, 5, 16'h7777); expect_v("R3", 5);
    wr(4'd6, 6, 16'h0009); expect_v("R3", 6);
    wr(4'd12, 3, 16'hFFFF); expect_v("R2", 3);
    // R4 zero mask, then R5/R10/R11 first restart of voices 0 and 3
    wr(4'd0, 0, 16'h0000); expect_v("R4", 3);
    ticks(2);
    wr(4'd0, 0, 16'h0009); expect_v("R5", 3); expect_v("R10", 0);
    // R7 end flags set, then restart voice 20 concurrent with its end_set
    step(1'b0, 4'd0, 0, '0, 1'b0, '0, 24'h100008); expect_v("R7", 3);
    wr(4'd5, 20, 16'h0040);
    step(1'b1, 4'd1, 0, 16'h0010, 1'b0, '0, 24'h100000); expect_v("R7", 20);
    // R6 gate: 3 ticks too few, 4th tick allows
    wr(4'd5, 3, 16'h2000);
    ticks(3);
    wr(4'd0, 0, 16'h0008); expect_v("R6", 3);
    ticks(1);
    wr(4'd0, 0, 16'h0008); expect_v("R6", 3); expect_v("R11", 3);
    // R8 release, zero mask release
    wr(4'd2, 0, 16'h0008); expect_v("R8", 3); expect_v("R8", 0);
    wr(4'd3, 0, 16'h0000); expect_v("R8", 20);
    wr(4'd3, 0, 16'h0010); expect_v("R8", 20);
    // R9 stop; stop with dropped restart; stop with accepted restart
    step(1'b0, 4'd0, 0, '0, 1'b0, 24'h000001, '0); expect_v("R9", 0);
    step(1'b1, 4'd0, 0, 16'h0008, 1'b0, 24'h000008, '0); expect_v("R9", 3);
    ticks(4);
    step(1'b1, 4'd0, 0, 16'h0008, 1'b1, 24'h000008, '0); expect_v("R9", 3);
    // R6 tick on the restart cycle is not counted
    ticks(3);
    wr(4'd0, 0, 16'h0008); expect_v("R6", 3);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule